// File: doc/BRIEF.md
# Synthesizer Serial Configuration Loader

This block holds the setup word for an external frequency synthesizer and delivers it over a three-wire serial link that only transmits. A host writes a 16-bit value in one cycle. The low 14 bits form the setup frame: a 3-bit test selector, a 2-bit output divider code and a 9-bit M count. The top two bits have no meaning and are never transmitted. The write itself acts as the enable that starts a transfer.

The control path produces a serial clock at the system clock divided by `CLK_DIV`. It shifts the frame out most significant bit first. Data changes when the serial clock falls and is stable while the clock is high. After the last bit, a strobe pulse latches the word inside the synthesizer. A busy flag covers the whole transfer.

A write that arrives during a transfer does not disturb that transfer. It updates the register, and the newest value goes out as soon as the current frame has been latched.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, `serClk`, `serData`, `serStrobe` and `busy` are all low.
- R2: A cycle with `hostWr` high loads `hostData` into the register and requests a transfer. `busy` is high from the next clock edge.
- R3: Only `hostData[13:0]` forms the frame. Bits 15 and 14 are never sent, so the word received equals `hostData[13:0]` whatever bits 15:14 hold.
- R4: Frame bits go out from bit 13 down to bit 0. Bits 13:11 carry the test selector, bits 10:9 the divider code and bits 8:0 the M count, so each field is sent MSB first in the order selector, divider, M count.
- R5: Each frame has exactly 14 rising edges of `serClk`. Each bit period lasts `CLK_DIV` system clocks, with the clock low for the first half and high for the second half.
- R6: `serData` changes only while `serClk` is low, so it is stable at and after every rising edge until the next falling edge.
- R7: After the 14th bit, `serStrobe` is high for exactly `CLK_DIV` system clocks, with `serClk` and `serData` held low.
- R8: `busy` stays high from the edge after the write until the edge where `serStrobe` falls, which gives 15*`CLK_DIV`+1 cycles for a lone write.
- R9: A write while busy does not abort the current frame. After that frame's strobe, the most recently written value is sent as the next frame, and `busy` stays high in between.
- R10: Whenever `busy` is low, all three serial lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | One-cycle host write and transfer enable |
| hostData | input | 16 | Register value written by the host |
| serClk | output | 1 | Serial clock to the synthesizer |
| serData | output | 1 | Serial data to the synthesizer |
| serStrobe | output | 1 | Latch strobe after the last bit |
| busy | output | 1 | Transfer pending or in progress |

## Verification
The frame is reconstructed from the wires and compared against words of all ones, all zeros with only the don't-care bits set, two alternating patterns, and a word built from distinct field values. The all-ones and all-zeros cases separate correct masking of bits 15:14 from leakage. The alternating patterns expose off-by-one shifts and reversed bit order. The field word catches fields that are swapped or mis-positioned. Back-to-back writes during a transfer show whether a late write aborts, is dropped, or correctly replaces an earlier pending write, and the exact busy length shows whether a cycle is lost or added between frames.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // copy register frame into shifter
    logic shift;  // advance shifter by one bit
  } ctrlStrobes_t;
endpackage

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int WORD_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic [REG_W-1:0] hostData,
  input  ctrlStrobes_t     strobes,
  output logic             serData
);
  logic [WORD_W-1:0] cfgReg;
  logic [WORD_W-1:0] shReg;
  logic              unusedDontCare;

  // Bits above the frame are don't-care and never stored for sending
  assign unusedDontCare = ^hostData[REG_W-1:WORD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (hostWr) begin
      cfgReg <= hostData[WORD_W-1:0];
    end
  end

  // Zero fill keeps the data line low once the frame is out
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.load) begin
      shReg <= cfgReg;
    end else if (strobes.shift) begin
      shReg <= {shReg[WORD_W-2:0], 1'b0};
    end
  end

  assign serData = shReg[WORD_W-1];
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int WORD_W  = 14,
  parameter int CLK_DIV = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output ctrlStrobes_t strobes,
  output logic         serClk,
  output logic         serStrobe,
  output logic         busy
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} state_t;

  state_t           stateQ;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             pendQ;
  logic             periodEnd;

  assign periodEnd     = (divCnt == DIV_LAST);
  assign strobes.load  = (stateQ == ST_IDLE) && pendQ;
  assign strobes.shift = (stateQ == ST_SHIFT) && periodEnd;

  // A new request overrides clearing, so a write during load is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else begin
      pendQ <= startReq | (pendQ & ~strobes.load);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          divCnt <= '0;
          bitCnt <= '0;
          if (pendQ) stateQ <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (periodEnd) begin
            divCnt <= '0;
            if (bitCnt == BIT_LAST) begin
              bitCnt <= '0;
              stateQ <= ST_LATCH;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          if (periodEnd) begin
            divCnt <= '0;
            stateQ <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign serClk    = (stateQ == ST_SHIFT) && (divCnt >= DIV_HALF);
  assign serStrobe = (stateQ == ST_LATCH);
  assign busy      = (stateQ != ST_IDLE) || pendQ;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int WORD_W  = 14,
  parameter int CLK_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic [REG_W-1:0] hostData,
  output logic             serClk,
  output logic             serData,
  output logic             serStrobe,
  output logic             busy
);
  ctrlStrobes_t strobes;

  synth_cfg_ctrl #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(hostWr), .strobes(strobes),
    .serClk(serClk), .serStrobe(serStrobe), .busy(busy)
  );

  synth_cfg_dp #(.REG_W(REG_W), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostData(hostData),
    .strobes(strobes), .serData(serData)
  );
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk #(
  parameter int WORD_W  = 14,
  parameter int CLK_DIV = 8
) (
  input logic clk,
  input logic rstN,
  input logic hostWr,
  input logic serClk,
  input logic serData,
  input logic serStrobe,
  input logic busy
);
  logic [15:0] edgeCnt;
  logic [15:0] strobeLen;
  logic        clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt   <= '0;
      strobeLen <= '0;
      clkPrev   <= 1'b0;
    end else begin
      clkPrev   <= serClk;
      strobeLen <= serStrobe ? strobeLen + 16'd1 : 16'd0;
      if (serStrobe) edgeCnt <= '0;
      else if (serClk && !clkPrev) edgeCnt <= edgeCnt + 16'd1;
    end
  end

  // R2
  wr_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> busy);
  // R5
  edge_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serStrobe) |-> edgeCnt == 16'(WORD_W));
  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));
  // R7
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    serStrobe |-> (!serClk && !serData));
  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serStrobe) |-> strobeLen == 16'(CLK_DIV));
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(serStrobe));
  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serClk && !serData && !serStrobe));
endmodule

bind synth_cfg_loader synth_cfg_chk #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .serClk(serClk),
  .serData(serData), .serStrobe(serStrobe), .busy(busy)
);

// File: tb/synth_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_loader_tb_top;
  localparam int CLK_DIV = 8;
  localparam int WORD_W  = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostData = '0;
  logic        serClk, serData, serStrobe, busy;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  synth_cfg_loader #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostData(hostData),
    .serClk(serClk), .serData(serData), .serStrobe(serStrobe), .busy(busy)
  );

  // Wire monitors
  int          cyc = 0;
  logic [13:0] rxShift = '0;
  int          rxBits = 0;
  logic [13:0] frames [0:15];
  int          frameBits [0:15];
  int          frameCnt = 0;
  int          lastRise = -1;
  int          badPeriod = 0;
  int          badHigh = 0;
  int          strobeRise = 0;
  int          strobeWidth = 0;

  always @(posedge clk) cyc++;

  always @(posedge serClk) begin
    if (rxBits > 0 && (cyc - lastRise) != CLK_DIV) badPeriod++;
    lastRise = cyc;
    rxShift  = {rxShift[12:0], serData};
    rxBits++;
  end

  always @(negedge serClk) begin
    if ((cyc - lastRise) != CLK_DIV / 2) badHigh++;
  end

  always @(posedge serStrobe) begin
    strobeRise = cyc;
    if (frameCnt < 16) begin
      frames[frameCnt]    = rxShift;
      frameBits[frameCnt] = rxBits;
    end
    frameCnt++;
    rxBits = 0;
  end

  always @(negedge serStrobe) strobeWidth = cyc - strobeRise;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] d);
    @(negedge clk);
    hostData = d;
    hostWr   = 1'b1;
    @(negedge clk);
    hostWr   = 1'b0;
  endtask

  task automatic test_reset();
    check(serClk == 1'b0,    "R1 serClk", serClk, 0);
    check(serData == 1'b0,   "R1 serData", serData, 0);
    check(serStrobe == 1'b0, "R1 serStrobe", serStrobe, 0);
    check(busy == 1'b0,      "R1 busy", busy, 0);
  endtask

  // Lone write: frame content, timing, busy length
  task automatic test_single(input logic [15:0] d, input string tag);
    int startFrames = frameCnt;
    int busyLen = 0;
    logic prevStrobe = 1'b0;
    badPeriod = 0;
    badHigh   = 0;
    hostWrite(d);
    check(busy == 1'b1, {"R2 busy after write ", tag}, busy, 1);
    while (busy && busyLen < 1000) begin
      prevStrobe = serStrobe;
      busyLen++;
      @(negedge clk);
    end
    check(prevStrobe && !serStrobe, {"R8 busy ends with strobe ", tag}, serStrobe, 0);
    check(busyLen == 15 * CLK_DIV + 1, {"R8 busy length ", tag}, busyLen, 15 * CLK_DIV + 1);
    check(frameCnt == startFrames + 1, {"R2 one frame ", tag}, frameCnt - startFrames, 1);
    check(frames[startFrames] == d[13:0], {"R3 R4 word ", tag}, frames[startFrames], d[13:0]);
    check(frameBits[startFrames] == WORD_W, {"R5 edges ", tag}, frameBits[startFrames], WORD_W);
    check(badPeriod == 0 && badHigh == 0, {"R5 clock shape ", tag}, badPeriod + badHigh, 0);
    check(strobeWidth == CLK_DIV, {"R7 strobe width ", tag}, strobeWidth, CLK_DIV);
    check(!serClk && !serData && !serStrobe, {"R10 idle lines ", tag},
          {serClk, serData, serStrobe}, 0);
  endtask

  // Writes during a transfer: the last one is sent next, no gap in busy
  task automatic test_overlap();
    int startFrames = frameCnt;
    int lowSeen = 0;
    logic [15:0] first  = 16'h1234;
    logic [15:0] second = 16'h0F0F;
    logic [15:0] third  = 16'h3A5C;
    hostWrite(first);
    repeat (3 * CLK_DIV) @(negedge clk);
    hostWrite(second);
    repeat (2 * CLK_DIV) @(negedge clk);
    hostWrite(third);
    for (int i = 0; i < 2000 && frameCnt < startFrames + 2; i++) begin
      if (!busy) lowSeen++;
      @(negedge clk);
    end
    while (busy) @(negedge clk);
    check(frameCnt == startFrames + 2, "R9 frame count", frameCnt - startFrames, 2);
    check(frames[startFrames] == first[13:0], "R9 first frame intact",
          frames[startFrames], first[13:0]);
    check(frames[startFrames + 1] == third[13:0], "R9 latest write sent",
          frames[startFrames + 1], third[13:0]);
    check(lowSeen == 0, "R9 busy continuous", lowSeen, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_single(16'hFFFF, "all ones");
    test_single(16'hC000, "only dont-care");
    test_single(16'h2AAA, "alt a");
    test_single(16'h1555, "alt b");
    test_single(16'h2000, "selector msb");
    test_single({2'b10, 3'd5, 2'd2, 9'h1A3}, "fields");
    test_single(16'h0001, "m lsb");
    test_overlap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule